// File: doc/BRIEF.md
# Two-Wire Serial Memory Page Write Controller

This block is the write side of a serial memory slave on a two-wire bus. The clock and data lines are synchronised to the system clock. START and STOP are detected as data-line edges while the bus clock is high. After a matching device address with a write direction bit, the block takes one word-address byte and then any number of data bytes. It acknowledges each accepted byte by pulling the data line low for the ninth bus clock. Data bytes land in an eight-entry page buffer. The write pointer steps only through its low three bits, so a long burst wraps onto the same page row.

A STOP that follows at least one data byte starts a self-timed commit of `COMMIT_CYCLES` system clocks. The commit is gated by the program-enable pin as sampled at that STOP. At the end of the commit, only the buffered entries that were actually written are copied into the behavioural array. While the commit runs, the block ignores the bus completely. A host can therefore poll with START plus the device address until that address is acknowledged again. An inspection port gives combinational access to the array contents.

Top module: `twi_page_writer`

## Requirements
- R1: A device-address byte is acknowledged only when its upper seven bits equal `DEV_ID` and its last (direction) bit is 0. Any other address byte is not acknowledged, and the block stays idle until the next START.
- R2: The word-address byte and every data byte are acknowledged with the data line pulled low during the ninth bus clock. The line is released after that clock's falling edge.
- R3: After each data byte, only the low three bits of the word pointer advance. The upper bits keep the page row set by the word-address byte.
- R4: A data byte that follows the last location of a page goes to the first location of the same page. With more than eight bytes, the later bytes overwrite the earlier ones in that page.
- R5: A STOP after one or more data bytes starts a commit. The array changes only when the commit ends, `COMMIT_CYCLES` clocks later. Only the locations that received data change, and the other locations in the page keep their contents.
- R6: During a commit, START and the device address are not acknowledged. After the commit, a START followed by the device address is acknowledged again.
- R7: If the program-enable pin is low at the STOP, the buffered data is discarded, the array does not change and no commit starts.
- R8: If the program-enable pin goes low after a commit has started, the commit still completes correctly.
- R9: A START in the middle of a transfer aborts it, and no buffered data from that transfer is ever committed.
- R10: A STOP with no data byte received starts no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | When 1, the block pulls the data line low |
| prog_en_i | input | 1 | Program enable; must be high at STOP for a commit |
| peek_addr_i | input | AW | Array inspection address |
| peek_data_o | output | 8 | Array contents at `peek_addr_i` |

## Verification
Several properties are checked on every cycle. The data line is never pulled during a commit. The pull only changes while the synchronised bus clock is low. A commit only begins on a STOP with program enable high. The page row stays fixed for as long as data bytes are being received. Other behaviour is only visible through the bench's scenarios: which address bytes are acknowledged, the wrap and overwrite within a page, the exact bytes left in the array after a commit, the refusal to acknowledge during polling, the effect of program enable, and the abort on a repeated START.

// File: rtl/twi_page_writer.sv
module twi_page_writer #(
  parameter logic [6:0] DEV_ID        = 7'h50,
  parameter int         AW            = 8,
  parameter int         PAGE_BITS     = 3,
  parameter int         COMMIT_CYCLES = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull_o,
  input  logic          prog_en_i,
  input  logic [AW-1:0] peek_addr_i,
  output logic [7:0]    peek_data_o
);
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PAGE_BITS;
  localparam int RW    = AW - PAGE_BITS;
  localparam int CW    = $clog2(COMMIT_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DEV, ST_WADDR, ST_DATA} st_t;

  logic [1:0] scl_sync, sda_sync;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  st_t        st;
  logic [3:0] bitcnt;
  logic [6:0] shreg;
  logic       ack_pend;
  logic       busy;
  logic [CW-1:0] cnt;
  logic [AW-1:0] ptr;
  logic [7:0]    pbuf [PAGE];
  logic [PAGE-1:0] valid;
  logic [7:0]    mem [DEPTH];

  assign scl_s = scl_sync[1];
  assign sda_s = sda_sync[1];

  wire scl_rise    = scl_s & ~scl_q;
  wire scl_fall    = ~scl_s & scl_q;
  wire start_det   = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det    = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] byte_in = {shreg, sda_s};
  wire commit_fire = busy && (cnt == '0);
  wire in_data     = (st == ST_DATA);
  wire [RW-1:0] row = ptr[AW-1:PAGE_BITS];
  wire [PAGE_BITS-1:0] col = ptr[PAGE_BITS-1:0];

  assign peek_data_o = mem[peek_addr_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      ack_pend   <= 1'b0;
      sda_pull_o <= 1'b0;
      busy       <= 1'b0;
      cnt        <= '0;
      ptr        <= '0;
      valid      <= '0;
      for (int k = 0; k < PAGE; k++) pbuf[k] <= '0;
    end else if (busy) begin
      if (commit_fire) begin
        busy  <= 1'b0;
        valid <= '0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (start_det) begin
      st         <= ST_DEV;
      bitcnt     <= '0;
      sda_pull_o <= 1'b0;
      valid      <= '0;
    end else if (stop_det) begin
      st         <= ST_IDLE;
      bitcnt     <= '0;
      sda_pull_o <= 1'b0;
      if ((|valid) && prog_en_i) begin
        busy <= 1'b1;
        cnt  <= CW'(COMMIT_CYCLES - 1);
      end else begin
        valid <= '0;
      end
    end else if (st != ST_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          shreg  <= byte_in[6:0];
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 4'd7) begin
            case (st)
              ST_DEV: begin
                if (byte_in[7:1] == DEV_ID && !byte_in[0]) begin
                  ack_pend <= 1'b1;
                  st       <= ST_WADDR;
                end else begin
                  ack_pend <= 1'b0;
                  st       <= ST_IDLE;
                  bitcnt   <= '0;
                end
              end
              ST_WADDR: begin
                ptr      <= byte_in[AW-1:0];
                ack_pend <= 1'b1;
                st       <= ST_DATA;
              end
              default: begin
                pbuf[col]  <= byte_in;
                valid[col] <= 1'b1;
                ptr        <= {row, col + 1'b1};
                ack_pend   <= 1'b1;
              end
            endcase
          end
        end else begin
          bitcnt <= 4'd9;
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          sda_pull_o <= ack_pend;
        end else if (bitcnt == 4'd9) begin
          sda_pull_o <= 1'b0;
          bitcnt     <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (commit_fire) begin
      for (int k = 0; k < PAGE; k++)
        if (valid[k]) mem[{row, PAGE_BITS'(k)}] <= pbuf[k];
    end
  end
endmodule

// File: rtl/twi_page_writer_chk.sv
module twi_page_writer_chk #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_pull,
  input logic          busy,
  input logic          prog_en,
  input logic          stop_det,
  input logic          in_data,
  input logic [RW-1:0] row
);
  p_no_ack_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);

  p_pull_on_low_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);

  p_commit_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_en) && $past(stop_det));

  p_row_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && $past(in_data)) |-> row == $past(row));
endmodule

bind twi_page_writer twi_page_writer_chk #(.RW(AW - PAGE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull(sda_pull_o),
  .busy(busy), .prog_en(prog_en_i), .stop_det(stop_det),
  .in_data(in_data), .row(row)
);

// File: tb/twi_page_writer_tb.sv
module twi_page_writer_tb_top;
  localparam int COMMIT = 300;
  localparam int Q = 6;
  localparam int NV = 7;
  // {address byte, expected ack}
  localparam logic [8:0] VEC [NV] = '{
    {8'hA0, 1'b1}, {8'hA1, 1'b0}, {8'hA2, 1'b0}, {8'h20, 1'b0},
    {8'hE0, 1'b0}, {8'h51, 1'b0}, {8'hA0, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic h_scl = 1, h_sda = 1, prog_en = 1;
  logic [7:0] peek_addr = 0;
  logic [7:0] peek_data;
  logic pull, line;
  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_mem [256];
  bit done = 0;

  always #5 clk = ~clk;
  assign line = h_sda & ~pull;

  twi_page_writer #(.DEV_ID(7'h50), .AW(8), .PAGE_BITS(3), .COMMIT_CYCLES(COMMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(h_scl), .sda_i(line), .sda_pull_o(pull),
    .prog_en_i(prog_en), .peek_addr_i(peek_addr), .peek_data_o(peek_data)
  );

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bstart(); h_sda = 1; wq(Q); h_scl = 1; wq(Q); h_sda = 0; wq(Q); h_scl = 0; wq(Q); endtask
  task automatic bstop(); h_sda = 0; wq(Q); h_scl = 1; wq(Q); h_sda = 1; wq(2*Q); endtask

  task automatic sbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      h_sda = b[i]; wq(Q); h_scl = 1; wq(2*Q); h_scl = 0; wq(Q);
    end
    h_sda = 1; wq(Q); h_scl = 1; wq(Q); ack = ~line; wq(Q); h_scl = 0; wq(Q);
  endtask

  task automatic peek(string req, logic [7:0] a);
    peek_addr = a; wq(1); check(req, peek_data, exp_mem[a]);
  endtask

  // write burst, model applies page wrap
  task automatic burst(string req, logic [7:0] wa, int n, logic [7:0] seed, bit upd);
    logic ack;
    bstart();
    sbyte(8'hA0, ack); check(req, {7'd0, ack}, 8'd1);
    sbyte(wa, ack);    check("R2", {7'd0, ack}, 8'd1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = seed + 8'(i * 7);
      sbyte(d, ack); check("R2", {7'd0, ack}, 8'd1);
      if (upd) exp_mem[{wa[7:3], 3'(wa[2:0] + 3'(i))}] = d;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    for (int a = 0; a < 256; a++) exp_mem[a] = 0;
    wq(4); rst_n = 1; wq(4);
    check("reset", {7'd0, pull}, 8'd0);
    peek("reset", 8'h05);

    // R1 / R10: address table, each closed by STOP without data
    for (int v = 0; v < NV; v++) begin
      bstart(); sbyte(VEC[v][8:1], ack); bstop();
      check("R1", {7'd0, ack}, {7'd0, VEC[v][0]});
    end

    // R5 / R6: single byte commit and polling
    burst("R1", 8'h05, 1, 8'h5A, 1);
    wq(Q); check("R2", {7'd0, line}, 8'd1);
    bstop();
    bstart(); sbyte(8'hA0, ack); bstop();
    check("R6", {7'd0, ack}, 8'd0);
    peek_addr = 8'h05; wq(1); check("R5", peek_data, 8'h00);
    wq(COMMIT + 40);
    peek("R5", 8'h05); peek("R5", 8'h04); peek("R5", 8'h06);
    bstart(); sbyte(8'hA0, ack); bstop();
    check("R6", {7'd0, ack}, 8'd1);

    // R3: pointer crosses end of page row, upper bits fixed
    burst("R3", 8'h3E, 3, 8'h11, 1); bstop(); wq(COMMIT + 40);
    peek("R3", 8'h3E); peek("R3", 8'h3F); peek("R3", 8'h38);
    peek("R3", 8'h40); peek("R3", 8'h39);

    // R4: ten bytes into an eight-byte page
    burst("R4", 8'h16, 10, 8'h80, 1); bstop(); wq(COMMIT + 40);
    for (int a = 8'h10; a < 8'h18; a++) peek("R4", 8'(a));
    peek("R4", 8'h18);

    // R7: program enable low at STOP
    prog_en = 0;
    burst("R7", 8'h70, 2, 8'hAA, 0); bstop();
    bstart(); sbyte(8'hA0, ack); bstop();
    check("R7", {7'd0, ack}, 8'd1);
    wq(COMMIT + 40);
    peek("R7", 8'h70); peek("R7", 8'h71);
    prog_en = 1;

    // R8: enable dropped during the commit
    burst("R8", 8'h71, 1, 8'hBB, 1); bstop();
    wq(3); prog_en = 0; wq(COMMIT + 40);
    peek("R8", 8'h71);
    prog_en = 1;

    // R9: repeated START aborts the buffered transfer
    burst("R9", 8'h72, 2, 8'hCC, 0);
    bstart(); sbyte(8'hA0, ack); bstop();
    check("R9", {7'd0, ack}, 8'd1);
    wq(COMMIT + 40);
    peek("R9", 8'h72); peek("R9", 8'h73);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule